// File: doc/BRIEF.md
# Speculative Branch History Register with Checkpoints

This block holds the global taken/not-taken history for one hardware thread. A front end shifts each predicted direction into the history as soon as the prediction is made. When it predicts a branch, it can also ask for a checkpoint. The block then saves the current history in a small tagged table and hands back the tag. The history width is `GHR_BITS`. The history sits in a register `STORE_BITS` wide, and elaboration stops with an error if `GHR_BITS` is larger than `STORE_BITS`.

When a branch resolves, the back end uses the tag for one of three actions:
- **Repair:** a wrong direction rebuilds the history from the saved value, shifted left by one, with the real outcome added in bit 0.
- **Restore:** a squash of the branch's path puts the saved value back unchanged and frees the tag.
- **Commit:** retirement only frees the tag.

The history output is plain and read-only, so index hashing can use it directly.

Top module: `spec_ghist`

## Requirements
- R1: Reset clears the history to 0 and frees every checkpoint slot. After reset, `snap_ok` is 1 and `snap_tag` is 0.
- R2: A speculative update (`spec_valid`) sets the history to `(history << 1) | spec_dir`, masked to `GHR_BITS` bits. The new value is visible after the next clock edge.
- R3: `snap_ok` and `snap_tag` are combinational. `snap_tag` shows the lowest-numbered free slot. A snapshot taken with `snap_req` stores the history as it was before any update in the same cycle.
- R4: A repair (`repair_valid`) sets the history to `((checkpoint[repair_tag] << 1) | repair_dir)`, masked to `GHR_BITS`. The slot stays allocated.
- R5: A restore (`restore_valid`) sets the history to exactly `checkpoint[restore_tag]`. The slot is free from the next cycle on.
- R6: A commit frees its slot and leaves the history unchanged. A cycle with no update, repair or restore also leaves the history unchanged.
- R7: When all `CKPT_DEPTH` slots are allocated, `snap_ok` is 0, and a snapshot request changes no slot.
- R8: In one cycle, restore has priority over repair, and repair has priority over a speculative update. An operation that loses has no effect on the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snap_req | input | 1 | Take a checkpoint of the current history |
| snap_ok | output | 1 | A free slot exists, so the request is granted |
| snap_tag | output | TAG_W | Tag of the slot that a snapshot would use |
| spec_valid | input | 1 | Speculative update |
| spec_dir | input | 1 | Predicted direction (1 = taken) |
| repair_valid | input | 1 | Repair after a direction misprediction |
| repair_tag | input | TAG_W | Checkpoint used for the repair |
| repair_dir | input | 1 | Resolved direction |
| restore_valid | input | 1 | Squash restore |
| restore_tag | input | TAG_W | Checkpoint restored and freed |
| commit_valid | input | 1 | Retire a checkpoint |
| commit_tag | input | TAG_W | Checkpoint freed on retirement |
| hist | output | GHR_BITS | Current global history |

## Verification
The results are due at different times:
- `snap_ok` and `snap_tag` react in the same cycle. The bench samples them at the falling edge after it drives the inputs, before the rising edge that would take the snapshot.
- The history and the slot table update on the next rising edge. A change to `hist` or a freed tag is therefore sampled at the falling edge that follows that edge, never earlier.
- The priority cases drive restore, repair and update in the same cycle. They then check that only the winner's value appears one edge later.

// File: rtl/spec_ghist.sv
module spec_ghist #(
  parameter int GHR_BITS   = 12,
  parameter int STORE_BITS = 32,
  parameter int CKPT_DEPTH = 8,
  localparam int TAG_W = (CKPT_DEPTH > 1) ? $clog2(CKPT_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snap_req,
  output logic                snap_ok,
  output logic [TAG_W-1:0]    snap_tag,
  input  logic                spec_valid,
  input  logic                spec_dir,
  input  logic                repair_valid,
  input  logic [TAG_W-1:0]    repair_tag,
  input  logic                repair_dir,
  input  logic                restore_valid,
  input  logic [TAG_W-1:0]    restore_tag,
  input  logic                commit_valid,
  input  logic [TAG_W-1:0]    commit_tag,
  output logic [GHR_BITS-1:0] hist
);

  localparam logic [STORE_BITS-1:0] MASK = (STORE_BITS'(1) << GHR_BITS) - STORE_BITS'(1);

  if (GHR_BITS > STORE_BITS || GHR_BITS < 1) begin : g_bad_width
    $error("spec_ghist: GHR_BITS must be in 1..STORE_BITS");
  end

  logic [STORE_BITS-1:0] ghr_q, ghr_d;
  logic [STORE_BITS-1:0] ckpt_q [CKPT_DEPTH];
  logic [CKPT_DEPTH-1:0] slot_vld, slot_vld_d;
  logic                  grant;

  always_comb begin
    snap_ok  = 1'b0;
    snap_tag = '0;
    for (int i = CKPT_DEPTH - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        snap_ok  = 1'b1;
        snap_tag = TAG_W'(i);
      end
    end
  end

  assign grant = snap_req && snap_ok;

  always_comb begin
    if (restore_valid)
      ghr_d = ckpt_q[restore_tag];
    else if (repair_valid)
      ghr_d = {ckpt_q[repair_tag][STORE_BITS-2:0], repair_dir};
    else if (spec_valid)
      ghr_d = {ghr_q[STORE_BITS-2:0], spec_dir};
    else
      ghr_d = ghr_q;
  end

  always_comb begin
    slot_vld_d = slot_vld;
    if (commit_valid)  slot_vld_d[commit_tag]  = 1'b0;
    if (restore_valid) slot_vld_d[restore_tag] = 1'b0;
    if (grant)         slot_vld_d[snap_tag]    = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghr_q    <= '0;
      slot_vld <= '0;
      for (int i = 0; i < CKPT_DEPTH; i++) ckpt_q[i] <= '0;
    end else begin
      ghr_q    <= ghr_d & MASK;
      slot_vld <= slot_vld_d;
      if (grant) ckpt_q[snap_tag] <= ghr_q;
    end
  end

  assign hist = ghr_q[GHR_BITS-1:0];

endmodule

// File: rtl/spec_ghist_chk.sv
module spec_ghist_chk #(
  parameter int GHR_BITS   = 12,
  parameter int CKPT_DEPTH = 8,
  localparam int TAG_W = (CKPT_DEPTH > 1) ? $clog2(CKPT_DEPTH) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                snap_req,
  input logic                snap_ok,
  input logic [TAG_W-1:0]    snap_tag,
  input logic                spec_valid,
  input logic                spec_dir,
  input logic                repair_valid,
  input logic                repair_dir,
  input logic                restore_valid,
  input logic [TAG_W-1:0]    restore_tag,
  input logic [GHR_BITS-1:0] hist,
  input logic [CKPT_DEPTH-1:0] slot_vld
);

  AST_SPEC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    spec_valid && !repair_valid && !restore_valid |=>
      hist == GHR_BITS'({$past(hist), $past(spec_dir)})); // R2

  AST_SNAP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req && snap_ok |-> !slot_vld[snap_tag]); // R3

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req && snap_ok |=> slot_vld[$past(snap_tag)]); // R3

  AST_REPAIR_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    repair_valid && !restore_valid |=> hist[0] == $past(repair_dir)); // R4

  AST_RESTORE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid && !(snap_req && snap_ok && snap_tag == restore_tag) |=>
      !slot_vld[$past(restore_tag)]); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_valid && !repair_valid && !restore_valid |=> $stable(hist)); // R6

  AST_FULL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_vld) == CKPT_DEPTH |-> !snap_ok); // R7

endmodule

bind spec_ghist spec_ghist_chk #(.GHR_BITS(GHR_BITS), .CKPT_DEPTH(CKPT_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .snap_req(snap_req), .snap_ok(snap_ok), .snap_tag(snap_tag),
  .spec_valid(spec_valid), .spec_dir(spec_dir), .repair_valid(repair_valid),
  .repair_dir(repair_dir), .restore_valid(restore_valid), .restore_tag(restore_tag),
  .hist(hist), .slot_vld(slot_vld)
);

// File: tb/test_spec_ghist.sv
module test_spec_ghist;
  localparam int GB = 12;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snap_req = 0, spec_valid = 0, spec_dir = 0, repair_valid = 0, repair_dir = 0;
  logic restore_valid = 0, commit_valid = 0;
  logic [TW-1:0] repair_tag = 0, restore_tag = 0, commit_tag = 0;
  logic snap_ok;
  logic [TW-1:0] snap_tag;
  logic [GB-1:0] hist;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spec_ghist #(.GHR_BITS(GB), .STORE_BITS(32), .CKPT_DEPTH(8)) i_spec_ghist (
    .clk(clk), .rst_n(rst_n), .snap_req(snap_req), .snap_ok(snap_ok), .snap_tag(snap_tag),
    .spec_valid(spec_valid), .spec_dir(spec_dir), .repair_valid(repair_valid),
    .repair_tag(repair_tag), .repair_dir(repair_dir), .restore_valid(restore_valid),
    .restore_tag(restore_tag), .commit_valid(commit_valid), .commit_tag(commit_tag),
    .hist(hist));

  // {dir, expected history after the update}
  localparam logic [12:0] VEC [8] = '{13'h1001, 13'h0002, 13'h1005, 13'h100B,
                                      13'h0016, 13'h102D, 13'h105B, 13'h00B6};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    snap_req = 0; spec_valid = 0; repair_valid = 0; restore_valid = 0; commit_valid = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(hist == 0, "R1 hist", hist, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(snap_ok == 1 && snap_tag == 0, "R1 slots", snap_tag, 0);

    for (int i = 0; i < 8; i++) begin
      spec_valid = 1; spec_dir = VEC[i][12];
      step();
      chk(hist == VEC[i][11:0], "R2 vector", hist, VEC[i][11:0]);
    end
    for (int i = 0; i < 5; i++) begin
      spec_valid = 1; spec_dir = 1;
      step();
    end
    chk(hist == 12'h6DF, "R2 mask", hist, 12'h6DF);

    snap_req = 1; spec_valid = 1; spec_dir = 0; #1;
    chk(snap_ok == 1 && snap_tag == 0, "R3 grant", snap_tag, 0);
    step();
    chk(hist == 12'hDBE, "R2 with snap", hist, 12'hDBE);
    spec_valid = 1; spec_dir = 1;
    step();
    chk(hist == 12'hB7D, "R2", hist, 12'hB7D);

    repair_valid = 1; repair_tag = 0; repair_dir = 1; spec_valid = 1; spec_dir = 0;
    step();
    chk(hist == 12'hDBF, "R4 R8 repair over spec", hist, 12'hDBF);
    snap_req = 1; #1;
    chk(snap_tag == 1, "R4 tag kept", snap_tag, 1);
    step();

    restore_valid = 1; restore_tag = 0; repair_valid = 1; repair_tag = 1; repair_dir = 0;
    spec_valid = 1; spec_dir = 1;
    step();
    chk(hist == 12'h6DF, "R5 R8 restore exact", hist, 12'h6DF);
    chk(snap_tag == 0, "R5 tag freed", snap_tag, 0);

    repair_valid = 1; repair_tag = 1; repair_dir = 0;
    step();
    chk(hist == 12'hB7E, "R4 dir0", hist, 12'hB7E);

    snap_req = 1;
    step();
    chk(snap_tag == 2, "R3 next free", snap_tag, 2);
    commit_valid = 1; commit_tag = 0;
    step();
    chk(snap_tag == 0, "R6 commit frees", snap_tag, 0);
    chk(hist == 12'hB7E, "R6 hist held", hist, 12'hB7E);

    for (int i = 0; i < 7; i++) begin
      snap_req = 1;
      step();
    end
    chk(snap_ok == 0, "R7 full", snap_ok, 0);
    snap_req = 1;
    step();
    commit_valid = 1; commit_tag = 3;
    step();
    chk(snap_ok == 1 && snap_tag == 3, "R7 request ignored", snap_tag, 3);
    chk(hist == 12'hB7E, "R6 idle hold", hist, 12'hB7E);

    restore_valid = 1; restore_tag = 1;
    step();
    chk(hist == 12'hDBF, "R5 restore tag1", hist, 12'hDBF);

    rst_n = 0; #1;
    chk(hist == 0 && snap_ok == 1 && snap_tag == 0, "R1 mid-run reset", hist, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule